// File: doc/BRIEF.md
# Scan Chain with Structural Test Sequencer

This block owns a bank of state flip-flops and places a two-way selector in front of each one. In functional mode every flip-flop takes its value from the next-state logic. In scan mode the bank becomes one serial shift register that is loaded from a serial input pin and read at a serial output pin. The flip-flop contents go out on a parallel bus that drives the logic under test. The primary outputs of that logic come back into the block.

A built-in sequencer runs the structural test cycle for each pattern. It shifts a state vector in, spends one clock in functional mode, and then shifts the captured state out. The primary outputs are sampled at the same edge as the capture. When a further pattern is queued, the unload of one response overlaps the load of the next stimulus. When no pattern is queued, a final drain phase empties the chain. Each response is assembled back into a parallel word and announced with a one-cycle strobe.

While the sequencer is idle, the mode input controls the bank directly. This is used for the chain-integrity test: a known bit sequence is shifted through the chain and checked at the serial output.

Top module: `scan_test_seq`

## Requirements
- R1: While reset is low, the chain is forced to the parameter `RESET_VAL`, which need not be zero. After reset: the sequencer is idle, `seq_busy` is 0, `resp_valid` is 0, `resp_po` is 0 and `scan_out` equals bit CHAIN_LEN-1 of the chain.
- R2: While the sequencer is idle and `scan_en` is 0, every flip-flop loads its own `func_next` bit at each clock.
- R3: While the chain is in scan mode, each clock moves bit i to bit i+1 and loads `scan_in` into bit 0. `scan_out` is always bit CHAIN_LEN-1, so a bit applied at `scan_in` appears at `scan_out` exactly CHAIN_LEN clocks later.
- R4: When the sequencer is idle and `pat_valid` is 1, `pat_take` is 1 in that same cycle. The next CHAIN_LEN cycles are a load phase with `scan_mode` 1 and `seq_busy` 1.
- R5: Each load phase is followed by exactly one capture cycle with `scan_mode` 0. At the end of that cycle the chain takes `func_next`, and `prim_out` is stored into `resp_po` at the same edge. `resp_po` changes at no other edge.
- R6: If `pat_valid` is 1 during a capture cycle, `pat_take` is 1 in that cycle. A new CHAIN_LEN-cycle shift phase then starts at once, loading the next stimulus while the captured response leaves at `scan_out`.
- R7: If `pat_valid` is 0 during a capture cycle, a CHAIN_LEN-cycle drain phase with `scan_mode` 1 follows, and then the sequencer returns to idle.
- R8: `resp_valid` is 1 for exactly one cycle, the cycle after the last shift edge of a phase that follows a capture. In that cycle `resp_state` equals the chain value that was captured, and `resp_po` equals the `prim_out` that was sampled. The first load after idle produces no strobe.
- R9: `scan_en` sets `scan_mode` only while the sequencer is idle. While `seq_busy` is 1, `scan_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Manual mode select used while idle (1 = shift) |
| func_next | input | CHAIN_LEN | Functional next-state values from the logic under test |
| prim_out | input | PO_W | Primary outputs of the logic under test |
| scan_in | input | 1 | Serial chain input |
| pat_valid | input | 1 | A further pattern is queued for loading |
| scan_out | output | 1 | Serial chain output (last flip-flop) |
| scan_mode | output | 1 | Selector control currently applied to every flip-flop |
| chain_q | output | CHAIN_LEN | Flip-flop contents feeding the logic under test |
| pat_take | output | 1 | Pattern accepted; its shift phase starts next cycle |
| seq_busy | output | 1 | Sequencer is not idle |
| resp_valid | output | 1 | One-cycle strobe: a response is complete |
| resp_state | output | CHAIN_LEN | Captured chain vector reassembled from scan_out |
| resp_po | output | PO_W | Primary outputs sampled at the capture edge |

## Verification
A wrong phase counter shows as a `scan_mode` edge in the wrong cycle and a strobe that is misplaced by the same amount. The reference model catches this at the first cycle where the phase length differs. A broken selector or link in the chain makes `scan_out` differ from the bit applied CHAIN_LEN clocks earlier, and the integrity test exposes this within one chain length. A wrong capture or collection order leaves `resp_state` either bit-reversed or shifted against the captured `func_next`, and this is visible at the first response strobe.

// File: rtl/scan_test_seq_pkg.sv
package scan_test_seq_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE    = 2'd0,
      SQ_SHIFT   = 2'd1,
      SQ_CAPTURE = 2'd2,
      SQ_UNLOAD  = 2'd3
   } seq_state_e;

endpackage

// File: rtl/scan_cell_bank.sv
module scan_cell_bank #(
   parameter int               CHAIN_LEN = 8,
   parameter logic [CHAIN_LEN-1:0] RESET_VAL = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode,
   input  logic                 scan_in,
   input  logic [CHAIN_LEN-1:0] func_next,
   output logic [CHAIN_LEN-1:0] q
);

   for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
      logic shift_src;
      logic cell_q;

      if (i == 0) begin : g_head
         assign shift_src = scan_in;
      end else begin : g_link
         assign shift_src = q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cell_q <= RESET_VAL[i];
         else        cell_q <= mode ? shift_src : func_next[i];
      end

      assign q[i] = cell_q;
   end

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
   import scan_test_seq_pkg::*;
#(
   parameter int CHAIN_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pat_valid,
   input  logic scan_en,
   output logic mode,
   output logic pat_take,
   output logic busy,
   output logic capture,
   output logic shift_phase,
   output logic phase_last
);

   localparam int CW = $clog2(CHAIN_LEN);
   localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);

   seq_state_e st, st_nx;
   logic [CW-1:0] cnt;

   assign shift_phase = (st == SQ_SHIFT) || (st == SQ_UNLOAD);
   assign capture     = (st == SQ_CAPTURE);
   assign busy        = (st != SQ_IDLE);
   assign mode        = shift_phase || ((st == SQ_IDLE) && scan_en);
   assign pat_take    = ((st == SQ_IDLE) || capture) && pat_valid;
   assign phase_last  = shift_phase && (cnt == LAST);

   always_comb begin
      st_nx = st;
      unique case (st)
         SQ_IDLE:    if (pat_valid)  st_nx = SQ_SHIFT;
         SQ_SHIFT:   if (phase_last) st_nx = SQ_CAPTURE;
         SQ_CAPTURE: st_nx = pat_valid ? SQ_SHIFT : SQ_UNLOAD;
         SQ_UNLOAD:  if (phase_last) st_nx = SQ_IDLE;
         default:    st_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SQ_IDLE;
         cnt <= '0;
      end else begin
         st <= st_nx;
         if (shift_phase && !phase_last) cnt <= cnt + 1'b1;
         else                            cnt <= '0;
      end
   end

endmodule

// File: rtl/scan_resp_unpack.sv
module scan_resp_unpack #(
   parameter int CHAIN_LEN = 8,
   parameter int PO_W      = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture,
   input  logic                 shift_phase,
   input  logic                 phase_last,
   input  logic                 scan_bit,
   input  logic [PO_W-1:0]      prim_out,
   output logic [CHAIN_LEN-1:0] resp_state,
   output logic [PO_W-1:0]      resp_po,
   output logic                 resp_valid
);

   logic pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend       <= 1'b0;
         resp_state <= '0;
         resp_po    <= '0;
         resp_valid <= 1'b0;
      end else begin
         resp_valid <= phase_last && pend;
         if (capture) begin
            pend    <= 1'b1;
            resp_po <= prim_out;
         end else if (phase_last) begin
            pend <= 1'b0;
         end
         if (shift_phase && pend)
            resp_state <= {resp_state[CHAIN_LEN-2:0], scan_bit};
      end
   end

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq #(
   parameter int                   CHAIN_LEN = 8,
   parameter int                   PO_W      = 4,
   parameter logic [CHAIN_LEN-1:0] RESET_VAL = CHAIN_LEN'('hA5)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scan_en,
   input  logic [CHAIN_LEN-1:0] func_next,
   input  logic [PO_W-1:0]      prim_out,
   input  logic                 scan_in,
   input  logic                 pat_valid,
   output logic                 scan_out,
   output logic                 scan_mode,
   output logic [CHAIN_LEN-1:0] chain_q,
   output logic                 pat_take,
   output logic                 seq_busy,
   output logic                 resp_valid,
   output logic [CHAIN_LEN-1:0] resp_state,
   output logic [PO_W-1:0]      resp_po
);

   if (CHAIN_LEN < 2) begin : g_len_check
      $error("scan_test_seq: CHAIN_LEN must be at least 2");
   end
   if (PO_W < 1) begin : g_po_check
      $error("scan_test_seq: PO_W must be at least 1");
   end

   logic capture, shift_phase, phase_last;

   scan_seq_ctrl #(.CHAIN_LEN(CHAIN_LEN)) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pat_valid  (pat_valid),
      .scan_en    (scan_en),
      .mode       (scan_mode),
      .pat_take   (pat_take),
      .busy       (seq_busy),
      .capture    (capture),
      .shift_phase(shift_phase),
      .phase_last (phase_last)
   );

   scan_cell_bank #(.CHAIN_LEN(CHAIN_LEN), .RESET_VAL(RESET_VAL)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (scan_mode),
      .scan_in  (scan_in),
      .func_next(func_next),
      .q        (chain_q)
   );

   assign scan_out = chain_q[CHAIN_LEN-1];

   scan_resp_unpack #(.CHAIN_LEN(CHAIN_LEN), .PO_W(PO_W)) unpack_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (capture),
      .shift_phase(shift_phase),
      .phase_last (phase_last),
      .scan_bit   (scan_out),
      .prim_out   (prim_out),
      .resp_state (resp_state),
      .resp_po    (resp_po),
      .resp_valid (resp_valid)
   );

endmodule

// File: rtl/scan_test_seq_chk.sv
module scan_test_seq_chk #(
   parameter int CHAIN_LEN = 8,
   parameter int PO_W      = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 scan_en,
   input logic                 scan_in,
   input logic [CHAIN_LEN-1:0] func_next,
   input logic                 scan_mode,
   input logic                 pat_take,
   input logic                 seq_busy,
   input logic [CHAIN_LEN-1:0] chain_q,
   input logic                 resp_valid,
   input logic [PO_W-1:0]      resp_po
);

   p_func_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_mode |=> chain_q == $past(func_next));

   p_shift_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
      scan_mode |=> chain_q[0] == $past(scan_in));

   p_shift_body_r3: assert property (@(posedge clk) disable iff (!rst_n)
      scan_mode |=> chain_q[CHAIN_LEN-1:1] == $past(chain_q[CHAIN_LEN-2:0]));

   p_take_starts_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pat_take |=> (scan_mode && seq_busy));

   p_capture_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && !scan_mode) |=> (scan_mode && seq_busy));

   p_po_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(seq_busy && !scan_mode) |=> $stable(resp_po));

   p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   p_idle_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_busy |-> scan_mode == scan_en);

endmodule

bind scan_test_seq scan_test_seq_chk #(.CHAIN_LEN(CHAIN_LEN), .PO_W(PO_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .scan_en   (scan_en),
   .scan_in   (scan_in),
   .func_next (func_next),
   .scan_mode (scan_mode),
   .pat_take  (pat_take),
   .seq_busy  (seq_busy),
   .chain_q   (chain_q),
   .resp_valid(resp_valid),
   .resp_po   (resp_po)
);

// File: tb/scan_test_seq_tb_top.sv
module scan_test_seq_tb_top;

   localparam int N = 8;
   localparam int P = 4;
   localparam logic [N-1:0] RV = 8'hA5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scan_en = 1'b0;
   logic [N-1:0] func_next = '0;
   logic [P-1:0] prim_out = '0;
   logic scan_in = 1'b0;
   logic pat_valid = 1'b0;
   logic scan_out, scan_mode, pat_take, seq_busy, resp_valid;
   logic [N-1:0] chain_q, resp_state;
   logic [P-1:0] resp_po;

   always #4 clk = ~clk;

   scan_test_seq #(.CHAIN_LEN(N), .PO_W(P), .RESET_VAL(RV)) dut_i (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .func_next(func_next),
      .prim_out(prim_out), .scan_in(scan_in), .pat_valid(pat_valid),
      .scan_out(scan_out), .scan_mode(scan_mode), .chain_q(chain_q),
      .pat_take(pat_take), .seq_busy(seq_busy), .resp_valid(resp_valid),
      .resp_state(resp_state), .resp_po(resp_po)
   );

   int checks = 0;
   int errors = 0;
   int wd = 0;
   logic [31:0] rnd = 32'h1234_5678;

   // reference model: 0 idle, 1 load/overlap shift, 2 capture, 3 drain
   logic [N-1:0] m_chain = RV;
   int           m_st = 0;
   int           m_cnt = 0;
   bit           m_pend = 0;
   logic [N-1:0] m_col = '0;
   logic [P-1:0] m_po = '0;
   bit           m_rv = 0;
   int           m_rv_cnt = 0;
   int           d_rv_cnt = 0;
   bit           sent[$];

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit m_mode();
      if (m_st == 1 || m_st == 3) return 1'b1;
      if (m_st == 2) return 1'b0;
      return scan_en;
   endfunction

   task automatic compare_all(string ph);
      bit pat = (ph == "P");
      chk(pat ? "R9" : ph, "scan_mode", 32'(scan_mode), 32'(m_mode()));
      chk(pat ? "R4" : ph, "pat_take", 32'(pat_take),
          32'((m_st == 0 || m_st == 2) && pat_valid));
      chk(pat ? "R7" : ph, "seq_busy", 32'(seq_busy), 32'(m_st != 0));
      chk(pat ? "R6" : ph, "chain_q", 32'(chain_q), 32'(m_chain));
      chk(pat ? "R3" : ph, "scan_out", 32'(scan_out), 32'(m_chain[N-1]));
      chk(pat ? "R5" : ph, "resp_po", 32'(resp_po), 32'(m_po));
      chk(pat ? "R8" : ph, "resp_valid", 32'(resp_valid), 32'(m_rv));
      if (m_rv) chk("R8", "resp_state", 32'(resp_state), 32'(m_col));
      if (resp_valid) d_rv_cnt++;
      if (ph == "R3" && sent.size() >= N)
         chk("R3", "integrity delay", 32'(scan_out), 32'(sent[sent.size()-N]));
   endtask

   task automatic model_step();
      bit md = m_mode();
      if (!rst_n) begin
         m_chain = RV; m_st = 0; m_cnt = 0; m_pend = 0; m_col = '0;
         m_po = '0; m_rv = 0; sent.delete();
         return;
      end
      m_rv = 0;
      if (md) begin
         if ((m_st == 1 || m_st == 3) && m_pend) m_col = {m_col[N-2:0], m_chain[N-1]};
         if (m_st == 0) sent.push_back(scan_in);
         m_chain = {m_chain[N-2:0], scan_in};
      end else begin
         sent.delete();
         if (m_st == 2) m_po = prim_out;
         m_chain = func_next;
      end
      case (m_st)
         0: if (pat_valid) begin m_st = 1; m_cnt = 0; end
         1, 3: begin
            if (m_cnt == N - 1) begin
               if (m_pend) begin m_rv = 1; m_rv_cnt++; end
               m_pend = 0;
               m_st = (m_st == 1) ? 2 : 0;
               m_cnt = 0;
            end else m_cnt++;
         end
         default: begin
            m_pend = 1;
            m_st = pat_valid ? 1 : 3;
            m_cnt = 0;
         end
      endcase
   endtask

   task automatic cyc(bit rst, bit se, bit pv, string ph);
      @(negedge clk);
      rnd = {rnd[30:0], rnd[31] ^ rnd[21] ^ rnd[1] ^ rnd[0]};
      rst_n = rst;
      scan_en = se;
      pat_valid = pv;
      func_next = rnd[7:0];
      prim_out = rnd[11:8];
      scan_in = rnd[12];
      #1;
      compare_all(ph);
      @(posedge clk);
      model_step();
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset value and idle outputs
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, "R1");
      cyc(1'b1, 1'b0, 1'b0, "R1");
      // R2: functional loads while idle
      for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 1'b0, "R2");
      // R3: chain-integrity shift
      for (int i = 0; i < 3 * N; i++) cyc(1'b1, 1'b1, 1'b0, "R3");
      // R4..R9: back-to-back patterns with scan_en toggled while busy
      for (int i = 0; i < 4 * (N + 1); i++) cyc(1'b1, rnd[13], 1'b1, "P");
      for (int i = 0; i < 3 * N; i++) cyc(1'b1, rnd[14], 1'b0, "P");
      // single isolated pattern, then drain to idle
      cyc(1'b1, 1'b0, 1'b1, "P");
      for (int i = 0; i < 3 * N; i++) cyc(1'b1, rnd[15], 1'b0, "P");
      cyc(1'b1, 1'b0, 1'b0, "R2");
      chk("R8", "response strobe count", 32'(d_rv_cnt), 32'(m_rv_cnt));
      chk("R8", "responses produced", 32'(m_rv_cnt > 2), 32'd1);
      summary();
      $finish;
   end

endmodule